// File: doc/BRIEF.md
# Pointer-Addressed I2C Register Target

This block is an I2C target that gives a bus master access to a small bank of registers through a pointer. The bank holds a read-only temperature word, an 8-bit configuration register and three 16-bit limit registers (low, high, critical). The block takes the SCL and SDA lines, synchronises them to its own clock and detects START, repeated START and STOP conditions. It decodes the 7-bit target address, takes a pointer byte and then either accepts write data or returns read data. It drives SDA low only through an open-drain enable.

The pointer keeps its last value. A master that polls one register repeatedly can therefore read with just an address byte. To read another register, the master writes the pointer, issues a repeated START and then addresses the block for reading. The register contents are presented on output ports for the neighbouring alarm logic. A one-cycle read strobe tells that logic when an acknowledged read transaction has ended, so it can clear its interrupt.

Top module: `ptri2c_target`

## Requirements
- R1: After reset the pointer selects code 0 (temperature), the configuration port reads 0x00, the limit ports hold their reset parameters (defaults low 0x0A00, high 0x2800, critical 0x3C00), SDA is released and the read strobe is low.
- R2: A read that consists only of the address byte with the direction bit set (address 0x48 by default) returns data from the register the pointer last selected.
- R3: A write carries the address byte, then a pointer byte whose low 3 bits select a register (1 configuration, 2 low limit, 3 high limit, 4 critical limit), then data. The configuration register takes the first data byte. A limit register is updated from its first (MSB) and second (LSB) data bytes together once the second byte arrives. A limit write that stops after one data byte leaves the register unchanged. Further data bytes are acknowledged and ignored.
- R4: Writes to pointer code 0 (temperature) and to the unused codes 5 to 7 are acknowledged and change no register. Reads of the unused codes return 0x00.
- R5: A write of the address and pointer byte, followed by a repeated START and the address with the read bit, returns data from the newly selected register.
- R6: Read data goes out MSB first within each byte. A 16-bit register sends its upper byte first and then alternates upper and lower bytes while the master keeps acknowledging. The configuration register sends its value in every byte.
- R7: During a read, an ACK from the master makes the block send the next byte. A NACK ends the read, and SDA stays released until the next START.
- R8: Reads and writes work the same whatever the configuration register holds, including its low-power request bit (bit 0).
- R9: Any detected START or STOP releases SDA on the following clock cycle and restarts address reception (START) or returns the block to idle (STOP), even in the middle of a byte.
- R10: An address byte whose upper 7 bits do not match the parameter is not acknowledged, and the block ignores the bus until the next START.
- R11: The temperature input is captured once per read transaction, during the acknowledge of the address byte. All temperature bytes of that transaction come from this one sample.
- R12: The read strobe pulses for exactly one clock when a START or STOP ends a read-direction transaction that the block acknowledged. Write-only transactions and unmatched addresses produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad (resolved wired-AND) |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| temp_i | input | REG_W | Current temperature word from the converter |
| cfg_q | output | CFG_W | Configuration register contents |
| lim_lo_q | output | REG_W | Low limit register contents |
| lim_hi_q | output | REG_W | High limit register contents |
| lim_crit_q | output | REG_W | Critical limit register contents |
| rd_strobe | output | 1 | One-cycle pulse at the end of an acknowledged read transaction |

## Verification
A sequencer that loses its bit count or phase shows up within one byte on the bus. An acknowledge lands in the wrong slot, or read data comes back shifted by one bit, so every byte the master receives is compared with a value worked out from the requirements. A wrong pointer or a wrong write-commit condition shows up on the register output ports right after the STOP, or in the next read. A missed START or STOP release would leave SDA held low. This would show in the very next address acknowledge and in the strobe count taken after each transaction.

// File: rtl/ptri2c_pkg.sv
`timescale 1ns/1ps
package ptri2c_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_PTR,
      ST_PACK,
      ST_WR,
      ST_WACK,
      ST_RD,
      ST_RACK,
      ST_SKIP
   } phase_e;

   localparam int SEL_W   = 3;
   localparam int NUM_LIM = 3;

   typedef logic [SEL_W-1:0] sel_t;

   localparam sel_t SEL_TEMP = 3'd0;
   localparam sel_t SEL_CFG  = 3'd1;
   localparam sel_t SEL_LO   = 3'd2;
   localparam sel_t SEL_HI   = 3'd3;
   localparam sel_t SEL_CRIT = 3'd4;

endpackage

// File: rtl/ptri2c_line_mon.sv
`timescale 1ns/1ps
module ptri2c_line_mon #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det,
   output logic sda_bit
);

   initial assert (SYNC_STAGES >= 1 && SYNC_STAGES <= 4)
      else $error("SYNC_STAGES must lie between 1 and 4");

   logic scl_s, sda_s;
   logic scl_q, sda_q;

   generate
      if (SYNC_STAGES == 1) begin : g_sync_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_s <= 1'b1;
               sda_s <= 1'b1;
            end else begin
               scl_s <= scl_i;
               sda_s <= sda_i;
            end
         end
      end else begin : g_sync_chain
         logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_sh <= '1;
               sda_sh <= '1;
            end else begin
               scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
               sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            end
         end
         assign scl_s = scl_sh[SYNC_STAGES-1];
         assign sda_s = sda_sh[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
   assign sda_bit   =  sda_s;

endmodule

// File: rtl/ptri2c_regbank.sv
`timescale 1ns/1ps
module ptri2c_regbank
   import ptri2c_pkg::*;
#(
   parameter int             REG_W    = 16,
   parameter int             CFG_W    = 8,
   parameter logic [15:0]    LO_RST   = 16'h0A00,
   parameter logic [15:0]    HI_RST   = 16'h2800,
   parameter logic [15:0]    CRIT_RST = 16'h3C00
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_stb,
   input  sel_t                              sel,
   input  logic                              wr_idx,
   input  logic [7:0]                        wr_data,
   input  logic                              cap_en,
   input  logic [REG_W-1:0]                  temp_i,
   input  logic                              rd_idx,
   output logic [7:0]                        rd_byte,
   output logic [CFG_W-1:0]                  cfg_q,
   output logic [NUM_LIM-1:0][REG_W-1:0]     lim_q
);

   initial assert (REG_W == 16) else $error("registers are two bytes wide");
   initial assert (CFG_W >= 1 && CFG_W <= 8) else $error("CFG_W must fit one byte");

   logic [7:0]       msb_hold;
   logic [REG_W-1:0] temp_sh;
   logic [15:0]      word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  msb_hold <= '0;
      else if (wr_stb && !wr_idx)  msb_hold <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       temp_sh <= '0;
      else if (cap_en)  temp_sh <= temp_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   cfg_q <= '0;
      else if (wr_stb && !wr_idx && sel == SEL_CFG) cfg_q <= wr_data[CFG_W-1:0];
   end

   generate
      for (genvar g = 0; g < NUM_LIM; g++) begin : g_lim
         localparam sel_t        MY_SEL = sel_t'(int'(SEL_LO) + g);
         localparam logic [15:0] RST_V  = (g == 0) ? LO_RST : (g == 1) ? HI_RST : CRIT_RST;
         logic [REG_W-1:0] val;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              val <= RST_V;
            else if (wr_stb && wr_idx && sel == MY_SEL) val <= {msb_hold, wr_data};
         end
         assign lim_q[g] = val;
      end
   endgenerate

   always_comb begin
      word = 16'h0000;
      case (sel)
         SEL_TEMP: word = temp_sh;
         SEL_CFG:  word = {8'(cfg_q), 8'(cfg_q)};
         SEL_LO:   word = lim_q[0];
         SEL_HI:   word = lim_q[1];
         SEL_CRIT: word = lim_q[2];
         default:  word = 16'h0000;
      endcase
   end

   assign rd_byte = rd_idx ? word[7:0] : word[15:8];

   AST_TEMP_WR_NOEFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && sel == SEL_TEMP) |=> ($stable(cfg_q) && $stable(lim_q))); // R4
   AST_LIM_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !wr_idx) |=> $stable(lim_q)); // R3

endmodule

// File: rtl/ptri2c_target.sv
`timescale 1ns/1ps
module ptri2c_target
   import ptri2c_pkg::*;
#(
   parameter logic [6:0]  TARGET_ADDR = 7'h48,
   parameter int          SYNC_STAGES = 2,
   parameter int          REG_W       = 16,
   parameter int          CFG_W       = 8,
   parameter logic [15:0] LO_RST      = 16'h0A00,
   parameter logic [15:0] HI_RST      = 16'h2800,
   parameter logic [15:0] CRIT_RST    = 16'h3C00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   input  logic [REG_W-1:0] temp_i,
   output logic [CFG_W-1:0] cfg_q,
   output logic [REG_W-1:0] lim_lo_q,
   output logic [REG_W-1:0] lim_hi_q,
   output logic [REG_W-1:0] lim_crit_q,
   output logic             rd_strobe
);

   localparam logic [1:0] WR_SAT = 2'd2;

   logic scl_rise, scl_fall, start_det, stop_det, sda_bit;

   ptri2c_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_bit   (sda_bit)
   );

   phase_e     state;
   logic [2:0] bit_cnt;
   logic       byte_full;
   logic [7:0] sh_in, sh_out;
   sel_t       sel_q;
   logic       rw_q, rd_idx, rd_seen, mnack;
   logic [1:0] wr_cnt;
   logic       sda_oe_q, rd_strobe_q;
   logic       wr_stb_q, wr_idx_q, cap_q;
   logic [7:0] wr_data_q;
   logic [7:0] rd_byte;
   logic [NUM_LIM-1:0][REG_W-1:0] lim_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         bit_cnt     <= '0;
         byte_full   <= 1'b0;
         sh_in       <= '0;
         sh_out      <= '1;
         sel_q       <= SEL_TEMP;
         rw_q        <= 1'b0;
         rd_idx      <= 1'b0;
         rd_seen     <= 1'b0;
         mnack       <= 1'b1;
         wr_cnt      <= '0;
         sda_oe_q    <= 1'b0;
         rd_strobe_q <= 1'b0;
         wr_stb_q    <= 1'b0;
         wr_idx_q    <= 1'b0;
         wr_data_q   <= '0;
         cap_q       <= 1'b0;
      end else begin
         wr_stb_q    <= 1'b0;
         cap_q       <= 1'b0;
         rd_strobe_q <= 1'b0;
         if (start_det || stop_det) begin
            state     <= start_det ? ST_ADDR : ST_IDLE;
            bit_cnt   <= '0;
            byte_full <= 1'b0;
            sda_oe_q  <= 1'b0;
            rd_idx    <= 1'b0;
            if (rd_seen) begin
               rd_strobe_q <= 1'b1;
               rd_seen     <= 1'b0;
            end
         end else if (scl_rise) begin
            case (state)
               ST_ADDR, ST_PTR, ST_WR: begin
                  sh_in   <= {sh_in[6:0], sda_bit};
                  bit_cnt <= bit_cnt + 3'd1;
                  if (bit_cnt == 3'd7) byte_full <= 1'b1;
               end
               ST_RD: begin
                  bit_cnt <= bit_cnt + 3'd1;
                  if (bit_cnt == 3'd7) byte_full <= 1'b1;
               end
               ST_AACK: if (rw_q) cap_q <= 1'b1;
               ST_RACK: mnack <= sda_bit;
               default: ;
            endcase
         end else if (scl_fall) begin
            case (state)
               ST_ADDR: if (byte_full) begin
                  byte_full <= 1'b0;
                  if (sh_in[7:1] == TARGET_ADDR) begin
                     rw_q     <= sh_in[0];
                     sda_oe_q <= 1'b1;
                     state    <= ST_AACK;
                  end else begin
                     state    <= ST_SKIP;
                  end
               end
               ST_AACK: begin
                  bit_cnt <= '0;
                  if (rw_q) begin
                     state    <= ST_RD;
                     rd_seen  <= 1'b1;
                     sda_oe_q <= ~rd_byte[7];
                     sh_out   <= {rd_byte[6:0], 1'b1};
                  end else begin
                     state    <= ST_PTR;
                     sda_oe_q <= 1'b0;
                  end
               end
               ST_PTR: if (byte_full) begin
                  byte_full <= 1'b0;
                  sel_q     <= sh_in[SEL_W-1:0];
                  sda_oe_q  <= 1'b1;
                  wr_cnt    <= '0;
                  state     <= ST_PACK;
               end
               ST_PACK: begin
                  sda_oe_q <= 1'b0;
                  state    <= ST_WR;
               end
               ST_WR: if (byte_full) begin
                  byte_full <= 1'b0;
                  sda_oe_q  <= 1'b1;
                  state     <= ST_WACK;
                  if (wr_cnt != WR_SAT) begin
                     wr_stb_q  <= 1'b1;
                     wr_data_q <= sh_in;
                     wr_idx_q  <= wr_cnt[0];
                  end
               end
               ST_WACK: begin
                  sda_oe_q <= 1'b0;
                  state    <= ST_WR;
                  if (wr_cnt != WR_SAT) wr_cnt <= wr_cnt + 2'd1;
               end
               ST_RD: begin
                  if (byte_full) begin
                     byte_full <= 1'b0;
                     sda_oe_q  <= 1'b0;
                     rd_idx    <= ~rd_idx;
                     state     <= ST_RACK;
                  end else begin
                     sda_oe_q <= ~sh_out[7];
                     sh_out   <= {sh_out[6:0], 1'b1};
                  end
               end
               ST_RACK: begin
                  if (!mnack) begin
                     state    <= ST_RD;
                     sda_oe_q <= ~rd_byte[7];
                     sh_out   <= {rd_byte[6:0], 1'b1};
                  end else begin
                     state    <= ST_SKIP;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   ptri2c_regbank #(
      .REG_W    (REG_W),
      .CFG_W    (CFG_W),
      .LO_RST   (LO_RST),
      .HI_RST   (HI_RST),
      .CRIT_RST (CRIT_RST)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_stb_q),
      .sel     (sel_q),
      .wr_idx  (wr_idx_q),
      .wr_data (wr_data_q),
      .cap_en  (cap_q),
      .temp_i  (temp_i),
      .rd_idx  (rd_idx),
      .rd_byte (rd_byte),
      .cfg_q   (cfg_q),
      .lim_q   (lim_q)
   );

   assign lim_lo_q   = lim_q[0];
   assign lim_hi_q   = lim_q[1];
   assign lim_crit_q = lim_q[2];
   assign sda_oe     = sda_oe_q;
   assign rd_strobe  = rd_strobe_q;

   AST_RELEASE_ON_COND: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det || stop_det) |=> !sda_oe); // R9
   AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> !sda_oe); // R10
   AST_DRIVE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> $past(scl_fall)); // R7
   AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe |-> $past(start_det || stop_det)); // R12
   AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe |=> !rd_strobe); // R12

endmodule

// File: tb/ptri2c_target_tb.sv
`timescale 1ns/1ps
module ptri2c_target_tb;

   localparam int         Q     = 8;
   localparam logic [7:0] WADDR = 8'h90;
   localparam logic [7:0] RADDR = 8'h91;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_scl = 1'b1;
   logic        m_sda = 1'b1;
   logic        sda_bus;
   logic        sda_oe;
   logic [15:0] temp_i = 16'h1234;
   logic [7:0]  cfg_q;
   logic [15:0] lim_lo_q, lim_hi_q, lim_crit_q;
   logic        rd_strobe;

   int nchk = 0;
   int nfail = 0;
   int stb_cnt = 0;
   int exp_stb = 0;

   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] obs_byte;
   event       obs_ev;

   always #5 clk = ~clk;

   assign sda_bus = m_sda & ~sda_oe;

   ptri2c_target u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (m_scl),
      .sda_i      (sda_bus),
      .sda_oe     (sda_oe),
      .temp_i     (temp_i),
      .cfg_q      (cfg_q),
      .lim_lo_q   (lim_lo_q),
      .lim_hi_q   (lim_hi_q),
      .lim_crit_q (lim_crit_q),
      .rd_strobe  (rd_strobe)
   );

   always @(posedge clk) if (rd_strobe) stb_cnt <= stb_cnt + 1;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic want(input logic [7:0] b, input string t);
      exp_q.push_back(b);
      tag_q.push_back(t);
   endtask

   initial forever begin
      @(obs_ev);
      if (exp_q.size() == 0) begin
         check(1'b0, "unexpected read byte", 32'(obs_byte), 32'h0);
      end else begin
         logic [7:0] e;
         string      t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(obs_byte == e, t, 32'(obs_byte), 32'(e));
      end
   end

   task automatic qwait();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; qwait();
      m_scl = 1'b1; qwait();
      m_sda = 1'b0; qwait();
      m_scl = 1'b0; qwait();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; qwait();
      m_scl = 1'b1; qwait();
      m_sda = 1'b1; qwait();
      qwait();
   endtask

   task automatic send_bit(input logic b);
      m_sda = b; qwait();
      m_scl = 1'b1; qwait(); qwait();
      m_scl = 1'b0; qwait();
   endtask

   task automatic get_bit(output logic b);
      m_sda = 1'b1; qwait();
      m_scl = 1'b1; qwait();
      b = sda_bus; qwait();
      m_scl = 1'b0; qwait();
   endtask

   task automatic send_byte(input logic [7:0] v, output logic acked);
      logic b;
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      get_bit(b);
      acked = ~b;
   endtask

   task automatic recv_byte(input logic last);
      logic [7:0] v;
      logic       b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      send_bit(last);
      obs_byte = v;
      ->obs_ev;
   endtask

   task automatic write_tx(input logic [2:0] sel, input int n, input logic [7:0] b0,
                           input logic [7:0] b1, input logic [7:0] b2, input string req);
      logic a;
      logic [7:0] d;
      bus_start();
      send_byte(WADDR, a);           check(a, {req, " addr ack"}, 32'(a), 32'h1);
      send_byte({5'b0, sel}, a);     check(a, {req, " pointer ack"}, 32'(a), 32'h1);
      for (int i = 0; i < n; i++) begin
         d = (i == 0) ? b0 : (i == 1) ? b1 : b2;
         send_byte(d, a);            check(a, {req, " data ack"}, 32'(a), 32'h1);
      end
      bus_stop();
   endtask

   task automatic read_tx(input bit set_ptr, input logic [2:0] sel, input int n, input string req);
      logic a;
      bus_start();
      if (set_ptr) begin
         send_byte(WADDR, a);        check(a, {req, " addr ack"}, 32'(a), 32'h1);
         send_byte({5'b0, sel}, a);  check(a, {req, " pointer ack"}, 32'(a), 32'h1);
         bus_start();
      end
      send_byte(RADDR, a);           check(a, {req, " read addr ack"}, 32'(a), 32'h1);
      for (int i = 0; i < n; i++) recv_byte(i == n - 1);
      bus_stop();
      exp_stb++;
      check(stb_cnt == exp_stb, "R12 strobe count", 32'(stb_cnt), 32'(exp_stb));
      check(sda_oe == 1'b0, "R7 released after NACK and STOP", 32'(sda_oe), 32'h0);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic a;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      qwait();

      // R1 reset state
      check(cfg_q == 8'h00, "R1 cfg reset", 32'(cfg_q), 32'h0);
      check(lim_lo_q == 16'h0A00, "R1 low reset", 32'(lim_lo_q), 32'h0A00);
      check(lim_hi_q == 16'h2800, "R1 high reset", 32'(lim_hi_q), 32'h2800);
      check(lim_crit_q == 16'h3C00, "R1 crit reset", 32'(lim_crit_q), 32'h3C00);
      check(sda_oe == 1'b0, "R1 sda released", 32'(sda_oe), 32'h0);
      check(stb_cnt == 0, "R1 no strobe", 32'(stb_cnt), 32'h0);

      // R1 R2 pointer at temperature after reset, address-only read
      want(8'h12, "R2 temp msb");
      want(8'h34, "R2 temp lsb");
      read_tx(1'b0, 3'd0, 2, "R2");

      // R3 configuration write, one data byte; R12 no strobe on write
      write_tx(3'd1, 1, 8'h5A, 8'h00, 8'h00, "R3 cfg");
      check(cfg_q == 8'h5A, "R3 cfg value", 32'(cfg_q), 32'h5A);
      check(stb_cnt == exp_stb, "R12 no strobe on write", 32'(stb_cnt), 32'(exp_stb));

      // R3 high limit two-byte write
      write_tx(3'd3, 2, 8'hBE, 8'hEF, 8'h00, "R3 high");
      check(lim_hi_q == 16'hBEEF, "R3 high value", 32'(lim_hi_q), 32'hBEEF);

      // R3 single byte to low limit commits nothing
      write_tx(3'd2, 1, 8'h77, 8'h00, 8'h00, "R3 partial");
      check(lim_lo_q == 16'h0A00, "R3 partial write ignored", 32'(lim_lo_q), 32'h0A00);

      // R3 extra byte ignored
      write_tx(3'd4, 3, 8'h12, 8'h34, 8'h56, "R3 extra");
      check(lim_crit_q == 16'h1234, "R3 third byte ignored", 32'(lim_crit_q), 32'h1234);

      // R4 write to temperature acknowledged but no effect
      write_tx(3'd0, 2, 8'hFF, 8'hFF, 8'h00, "R4 temp write");
      check(cfg_q == 8'h5A && lim_hi_q == 16'hBEEF && lim_lo_q == 16'h0A00 && lim_crit_q == 16'h1234,
            "R4 registers unchanged", 32'(lim_hi_q), 32'hBEEF);
      want(8'h12, "R4 temp msb after write");
      want(8'h34, "R4 temp lsb after write");
      read_tx(1'b1, 3'd0, 2, "R4");

      // R5 repeated-start read of high limit
      want(8'hBE, "R5 high msb");
      want(8'hEF, "R5 high lsb");
      read_tx(1'b1, 3'd3, 2, "R5");

      // R2 sticky pointer, R6 alternating bytes
      want(8'hBE, "R2 sticky msb");
      want(8'hEF, "R6 lsb");
      want(8'hBE, "R6 wraps to msb");
      read_tx(1'b0, 3'd0, 3, "R6");

      // R6 configuration repeats
      want(8'h5A, "R6 cfg byte 0");
      want(8'h5A, "R6 cfg byte 1");
      read_tx(1'b1, 3'd1, 2, "R6 cfg");

      // R4 unused pointer code
      write_tx(3'd5, 2, 8'h11, 8'h22, 8'h00, "R4 unused");
      check(cfg_q == 8'h5A && lim_hi_q == 16'hBEEF && lim_crit_q == 16'h1234,
            "R4 unused write no effect", 32'(cfg_q), 32'h5A);
      want(8'h00, "R4 unused reads zero");
      read_tx(1'b1, 3'd5, 1, "R4 unused");

      // R10 address mismatch
      bus_start();
      send_byte(8'h92, a);
      check(a == 1'b0, "R10 mismatch not acked", 32'(a), 32'h0);
      send_byte(8'h00, a);
      check(a == 1'b0, "R10 ignored after mismatch", 32'(a), 32'h0);
      bus_stop();
      check(stb_cnt == exp_stb, "R12 no strobe on mismatch", 32'(stb_cnt), 32'(exp_stb));

      // R11 temperature shadow holds across bytes
      temp_i = 16'hA55A;
      bus_start();
      send_byte(WADDR, a);   check(a, "R11 addr ack", 32'(a), 32'h1);
      send_byte(8'h00, a);   check(a, "R11 pointer ack", 32'(a), 32'h1);
      bus_start();
      send_byte(RADDR, a);   check(a, "R11 read addr ack", 32'(a), 32'h1);
      want(8'hA5, "R11 msb of sample");
      recv_byte(1'b0);
      temp_i = 16'h0FF0;
      want(8'h5A, "R11 lsb of same sample");
      recv_byte(1'b1);
      bus_stop();
      exp_stb++;
      check(stb_cnt == exp_stb, "R12 strobe after shadow read", 32'(stb_cnt), 32'(exp_stb));
      want(8'h0F, "R11 new sample msb");
      want(8'hF0, "R11 new sample lsb");
      read_tx(1'b0, 3'd0, 2, "R11");

      // R7 one-byte read of 16-bit register ended by NACK
      want(8'hBE, "R7 single byte");
      read_tx(1'b1, 3'd3, 1, "R7");

      // R9 write aborted mid-byte by repeated START
      bus_start();
      send_byte(WADDR, a);   check(a, "R9 addr ack", 32'(a), 32'h1);
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      bus_start();
      check(sda_oe == 1'b0, "R9 released at START", 32'(sda_oe), 32'h0);
      send_byte(RADDR, a);   check(a, "R9 address after abort", 32'(a), 32'h1);
      want(8'hBE, "R9 pointer kept msb");
      want(8'hEF, "R9 pointer kept lsb");
      recv_byte(1'b0);
      recv_byte(1'b1);
      bus_stop();
      exp_stb++;
      check(stb_cnt == exp_stb, "R12 strobe after abort read", 32'(stb_cnt), 32'(exp_stb));
      check(sda_oe == 1'b0, "R9 released at STOP", 32'(sda_oe), 32'h0);

      // R8 access with low-power request bit set
      write_tx(3'd1, 1, 8'h01, 8'h00, 8'h00, "R8 cfg");
      check(cfg_q == 8'h01, "R8 cfg low-power bit", 32'(cfg_q), 32'h01);
      write_tx(3'd2, 2, 8'h11, 8'h11, 8'h00, "R8 low");
      check(lim_lo_q == 16'h1111, "R8 write while low-power", 32'(lim_lo_q), 32'h1111);
      want(8'h11, "R8 read msb");
      want(8'h11, "R8 read lsb");
      read_tx(1'b0, 3'd0, 2, "R8");

      qwait();
      check(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 32'h0);
      finish_run();
   end

endmodule